// File: doc/BRIEF.md
# Multi-lane audio serial port

This block is the per-slot audio engine between a 32-bit sample stream and one converter module. In output mode it takes samples over a valid/ready stream and sends them on up to four serial data lanes that share one bit clock and one word clock. In input mode it samples the same lanes and hands the captured words back as a 32-bit stream. Everything runs in the audio master clock domain. The bit clock is produced as a clock-enable-timed register output.

A configuration word is applied while the block is disabled. It selects the direction, the serial format (I2S, left-justified or right-justified), the number of active lanes and the bit clock divide ratio. Each frame holds 64 bit clocks. The first 32 are the left half and the last 32 are the right half. Each half carries one word of `WORD_BITS` bits per lane. The word is taken from the top bits of the 32-bit sample.

Top module: `audio_lane_port`

## Requirements
- R1: `bclk` is high for `cfgDivHalf` master clocks and then low for `cfgDivHalf` master clocks. A value of 0 acts as 1. A frame is 64 bit clocks. `lrck` is low for 32 bit clocks (left) and then high for 32 (right), and it changes only when `bclk` falls.
- R2: With `cfgFormat` = 0 (I2S), and also with code 3, the word MSB sits in the second bit slot of each half. The `WORD_BITS` bits follow MSB first, and every other slot of an active lane is 0.
- R3: With `cfgFormat` = 1 (left-justified), the word MSB sits in the first bit slot of each half.
- R4: With `cfgFormat` = 2 (right-justified), the word LSB sits in the last (32nd) bit slot of each half.
- R5: Lane count is `cfgLanes`+1. The samples of one frame are taken in the order lane 0 left, lane 0 right, lane 1 left, lane 1 right, and so on. Lane n carries pair n. Bits [31:32-WORD_BITS] of a sample are sent. Lanes above the count stay at 0.
- R6: At a frame start in output mode, the block may not hold all 2×lanes samples for that frame. In that case the whole frame is sent as zeros, `underrun` is set and stays set until the block is disabled, and samples already accepted are kept for a later frame.
- R7: `txReady` is high only when the block is enabled in output mode and the next frame is not yet full. `rxValid` is never high in output mode.
- R8: In input mode, each active lane is sampled when `bclk` rises, at the same bit slots as in output. At the end of each frame, that frame's words are offered on `rxData` in the R5 order. Each word is placed in bits [31:32-WORD_BITS] with the low bits zero. Words not taken before the next frame end are replaced.
- R9: While `cfgEnable` is low, `bclk`, `lrck` and `sdOut` are low, `txReady` and `rxValid` are low, and `underrun` is cleared.
- R10: The first frame after enabling in output mode is all zeros, and it consumes no samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Audio master clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgEnable | input | 1 | Runs the port; configuration changes only while low |
| cfgDirOut | input | 1 | 1 = send samples (output), 0 = capture (input) |
| cfgFormat | input | 2 | 0 I2S, 1 left-justified, 2 right-justified, 3 as I2S |
| cfgLanes | input | 2 | Active lane count minus one |
| cfgDivHalf | input | DIV_W | Master clocks per bit clock half period |
| txValid | input | 1 | Output-side sample valid |
| txReady | output | 1 | Output-side sample accepted |
| txData | input | 32 | Output-side sample |
| rxValid | output | 1 | Captured sample valid |
| rxReady | input | 1 | Consumer takes the captured sample |
| rxData | output | 32 | Captured sample, MSB aligned |
| bclk | output | 1 | Bit clock |
| lrck | output | 1 | Word clock, low = left |
| sdOut | output | LANES | Serial data to the converter |
| sdIn | input | LANES | Serial data from the converter |
| underrun | output | 1 | Sticky flag: a frame went out as zeros |

## Verification
Output mode is exercised three ways, each with a distinct hash-derived sample pattern per channel:
- I2S on four lanes at the fastest bit clock.
- Left-justified on two lanes at half that rate.
- Right-justified on one lane.

Because every channel word is unique, a swap of channel order, lane mapping or left/right half shows up as a mismatch. Checking the bit slots outside the data window separates the three alignments.

Input mode is exercised with a bench-side serializer in three ways: four lanes in I2S, three in right-justified and two in left-justified, with the consumer throttled. This shows both capture alignment and ordering. Stopping the output-side supply after a run shows the zero-frame and sticky-flag behaviour.

// File: rtl/alp_pkg.sv
package alp_pkg;
  localparam int SAMPLE_W = 32;
  localparam int SLOT_W   = 5;

  typedef enum logic [1:0] {
    FMT_I2S   = 2'b00,
    FMT_LEFT  = 2'b01,
    FMT_RIGHT = 2'b10,
    FMT_ALT   = 2'b11
  } fmt_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              fallTick;
    logic              riseTick;
    logic              wrapTick;
    logic              inWin;
    logic              half;
    logic [SLOT_W-1:0] bitIdx;
  } strobe_t;
endpackage

// File: rtl/alp_ctrl.sv
module alp_ctrl #(
  parameter int WORD_BITS = 24,
  parameter int DIV_W     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              en,
  input  logic [1:0]        fmt,
  input  logic [DIV_W-1:0]  divHalf,
  output logic              bclk,
  output logic              lrck,
  output alp_pkg::strobe_t  stb
);
  import alp_pkg::*;

  localparam logic [5:0] RJ_START = 6'(32 - WORD_BITS);

  logic [DIV_W-1:0] divCnt, divLim;
  logic [5:0]       bitPos;
  logic             atLim;
  logic [5:0]       startSlot, slotExt, off;

  assign divLim = (divHalf == '0) ? '0 : divHalf - 1'b1;
  assign atLim  = en && (divCnt >= divLim);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      bclk   <= 1'b0;
      bitPos <= '0;
    end else if (!en) begin
      divCnt <= '0;
      bclk   <= 1'b0;
      bitPos <= '0;
    end else if (atLim) begin
      divCnt <= '0;
      bclk   <= ~bclk;
      if (bclk) bitPos <= bitPos + 6'd1;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign lrck = bitPos[5];

  always_comb begin
    case (fmt_e'(fmt))
      FMT_LEFT:  startSlot = 6'd0;
      FMT_RIGHT: startSlot = RJ_START;
      default:   startSlot = 6'd1;
    endcase
  end

  assign slotExt = {1'b0, bitPos[4:0]};
  assign off     = slotExt - startSlot;

  assign stb.fallTick = atLim && bclk;
  assign stb.riseTick = atLim && !bclk;
  assign stb.wrapTick = atLim && bclk && (bitPos == 6'd63);
  assign stb.inWin    = (slotExt >= startSlot) && (off < 6'(WORD_BITS));
  assign stb.half     = bitPos[5];
  assign stb.bitIdx   = 5'd31 - off[4:0];
endmodule

// File: rtl/alp_dpath.sv
module alp_dpath #(
  parameter int LANES  = 4,
  parameter int LANE_W = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          en,
  input  logic                          dirOut,
  input  logic [LANE_W-1:0]             lanesM1,
  input  alp_pkg::strobe_t              stb,
  input  logic                          txValid,
  output logic                          txReady,
  input  logic [alp_pkg::SAMPLE_W-1:0]  txData,
  output logic                          rxValid,
  input  logic                          rxReady,
  output logic [alp_pkg::SAMPLE_W-1:0]  rxData,
  output logic [LANES-1:0]              sdOut,
  input  logic [LANES-1:0]              sdIn,
  output logic                          underrun
);
  import alp_pkg::*;

  localparam int CH    = 2 * LANES;
  localparam int IDX_W = $clog2(CH);
  localparam int CNT_W = IDX_W + 1;

  logic [SAMPLE_W-1:0] nextBuf  [CH];
  logic [SAMPLE_W-1:0] frameBuf [CH];
  logic [SAMPLE_W-1:0] capBuf   [CH];
  logic [SAMPLE_W-1:0] outBuf   [CH];
  logic [CNT_W-1:0]    fillCnt, rxIdx, need;
  logic                txMode, rxMode, txTake, underrunQ;

  assign need    = CNT_W'({lanesM1, 1'b0}) + CNT_W'(2);
  assign txMode  = en && dirOut;
  assign rxMode  = en && !dirOut;
  assign txReady = txMode && (fillCnt < need);
  assign txTake  = txValid && txReady;
  assign underrun = underrunQ;

  // output side: stage next frame, swap at frame wrap
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillCnt   <= '0;
      underrunQ <= 1'b0;
      for (int i = 0; i < CH; i++) begin
        frameBuf[i] <= '0;
        nextBuf[i]  <= '0;
      end
    end else if (!txMode) begin
      fillCnt   <= '0;
      underrunQ <= 1'b0;
      for (int i = 0; i < CH; i++) frameBuf[i] <= '0;
    end else begin
      if (txTake) nextBuf[fillCnt[IDX_W-1:0]] <= txData;
      if (stb.wrapTick && (fillCnt == need)) begin
        for (int i = 0; i < CH; i++) frameBuf[i] <= nextBuf[i];
        fillCnt <= '0;
      end else begin
        if (stb.wrapTick) begin
          for (int i = 0; i < CH; i++) frameBuf[i] <= '0;
          underrunQ <= 1'b1;
        end
        if (txTake) fillCnt <= fillCnt + 1'b1;
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [IDX_W-1:0] chSel;
    assign chSel    = IDX_W'(2 * l) + IDX_W'(stb.half);
    assign sdOut[l] = txMode && stb.inWin && (LANE_W'(l) <= lanesM1)
                      && frameBuf[chSel][stb.bitIdx];
  end

  // input side: capture on rising bit clock, publish at frame wrap
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxIdx <= CNT_W'(CH);
      for (int i = 0; i < CH; i++) begin
        capBuf[i] <= '0;
        outBuf[i] <= '0;
      end
    end else if (!rxMode) begin
      rxIdx <= CNT_W'(CH);
      for (int i = 0; i < CH; i++) capBuf[i] <= '0;
    end else begin
      if (stb.riseTick && stb.inWin) begin
        for (int l = 0; l < LANES; l++)
          if (LANE_W'(l) <= lanesM1)
            capBuf[IDX_W'(2 * l) + IDX_W'(stb.half)][stb.bitIdx] <= sdIn[l];
      end
      if (stb.wrapTick) begin
        for (int i = 0; i < CH; i++) outBuf[i] <= capBuf[i];
        rxIdx <= '0;
      end else if (rxValid && rxReady) begin
        rxIdx <= rxIdx + 1'b1;
      end
    end
  end

  assign rxValid = rxMode && (rxIdx < need);
  assign rxData  = outBuf[rxIdx[IDX_W-1:0]];
endmodule

// File: rtl/audio_lane_port.sv
module audio_lane_port #(
  parameter int WORD_BITS = 24,
  parameter int LANES     = 4,
  parameter int DIV_W     = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgEnable,
  input  logic                 cfgDirOut,
  input  logic [1:0]           cfgFormat,
  input  logic [1:0]           cfgLanes,
  input  logic [DIV_W-1:0]     cfgDivHalf,
  input  logic                 txValid,
  output logic                 txReady,
  input  logic [31:0]          txData,
  output logic                 rxValid,
  input  logic                 rxReady,
  output logic [31:0]          rxData,
  output logic                 bclk,
  output logic                 lrck,
  output logic [LANES-1:0]     sdOut,
  input  logic [LANES-1:0]     sdIn,
  output logic                 underrun
);
  alp_pkg::strobe_t stb;

  alp_ctrl #(.WORD_BITS(WORD_BITS), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .en(cfgEnable), .fmt(cfgFormat),
    .divHalf(cfgDivHalf), .bclk(bclk), .lrck(lrck), .stb(stb)
  );

  alp_dpath #(.LANES(LANES), .LANE_W(2)) u_dpath (
    .clk(clk), .rstN(rstN), .en(cfgEnable), .dirOut(cfgDirOut),
    .lanesM1(cfgLanes), .stb(stb),
    .txValid(txValid), .txReady(txReady), .txData(txData),
    .rxValid(rxValid), .rxReady(rxReady), .rxData(rxData),
    .sdOut(sdOut), .sdIn(sdIn), .underrun(underrun)
  );
endmodule

// File: rtl/alp_checker.sv
module alp_checker #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgEnable,
  input logic             cfgDirOut,
  input logic [1:0]       cfgLanes,
  input logic             txReady,
  input logic             rxValid,
  input logic             bclk,
  input logic             lrck,
  input logic [LANES-1:0] sdOut,
  input logic             underrun
);
  AST_READY_NEEDS_TX: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> (cfgEnable && cfgDirOut)); // R7

  AST_NO_RX_IN_TX: assert property (@(posedge clk) disable iff (!rstN)
    cfgDirOut |-> !rxValid); // R7

  AST_LRCK_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEnable && $past(cfgEnable) && (lrck != $past(lrck))) |-> $fell(bclk)); // R1

  AST_UNDERRUN_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEnable && cfgDirOut && $past(cfgEnable) && $past(cfgDirOut) && $past(underrun))
      |-> underrun); // R6

  AST_UPPER_LANES_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (cfgLanes == 2'd0) |-> (sdOut[LANES-1:1] == '0)); // R5

  AST_OFF_CLOCKS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable |=> (!bclk && !lrck && !underrun)); // R9

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable |-> ((sdOut == '0) && !txReady && !rxValid)); // R9
endmodule

bind audio_lane_port alp_checker #(.LANES(LANES)) u_chk (.*);

// File: tb/sim_audio_lane_port.sv
module sim_audio_lane_port;
  localparam int W  = 24;
  localparam int SH = 32 - W;

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgEnable = 1'b0, cfgDirOut = 1'b0;
  logic [1:0] cfgFormat = 2'd0, cfgLanes = 2'd0;
  logic [3:0] cfgDivHalf = 4'd1;
  logic txValid = 1'b0, rxReady = 1'b0;
  logic [31:0] txData = '0;
  logic txReady, rxValid, bclk, lrck, underrun;
  logic [31:0] rxData;
  logic [3:0] sdOut;
  logic [3:0] sdIn = '0;

  int total = 0, bad = 0, cyc = 0;
  logic [31:0] expQ[$];

  // output-side monitor state
  bit monOn = 0;
  int mSlot, mStart, mLanes, mZero, mDiv, mLastRise, mNoise, mPeriodBad, mHalfBad;
  logic mPrevB, mPrevL;
  logic [31:0] acc [4][2];
  string mTag;
  // input-side driver state
  bit rxOn = 0;
  int sSlot, sFrame, sStart, sLanes, sFrames;
  logic sPrevB, sPrevL;

  always #2.5 clk = ~clk;

  audio_lane_port u0 (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgDirOut(cfgDirOut),
    .cfgFormat(cfgFormat), .cfgLanes(cfgLanes), .cfgDivHalf(cfgDivHalf),
    .txValid(txValid), .txReady(txReady), .txData(txData),
    .rxValid(rxValid), .rxReady(rxReady), .rxData(rxData),
    .bclk(bclk), .lrck(lrck), .sdOut(sdOut), .sdIn(sdIn), .underrun(underrun)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] txWord(input int f, input int i);
    return (32'(f * 8 + i + 1) * 32'h9E3779B9) ^ 32'h5A5A0F0F;
  endfunction

  function automatic logic [31:0] rxWord(input int f, input int i);
    return (32'(f * 16 + i + 7) * 32'h2545F491) ^ 32'hC3A55A3C;
  endfunction

  function automatic int startOf(input int fmt);
    return (fmt == 1) ? 0 : (fmt == 2) ? (32 - W) : 1;
  endfunction

  task automatic monFrameDone();
    logic [31:0] e;
    for (int l = 0; l < 4; l++)
      for (int h = 0; h < 2; h++) begin
        if (l < mLanes) begin
          if (mZero > 0 || expQ.size() == 0) e = '0;
          else e = expQ.pop_front();
          chk(acc[l][h][W-1:0] == e[31:SH], (mZero > 0) ? "R10" : "R5",
              {mTag, " lane word"}, 32'(acc[l][h][W-1:0]), 32'(e[31:SH]));
        end else begin
          chk(acc[l][h] == 0, "R5", "unused lane", acc[l][h], 0);
        end
      end
    if (mZero > 0) mZero--;
    chk(mNoise == 0, mTag, "bits outside word window", 32'(mNoise), 0);
    chk(mPeriodBad == 0 && mHalfBad == 0, "R1", "bit clock / word clock shape",
        32'(mPeriodBad + mHalfBad), 0);
    mNoise = 0; mPeriodBad = 0; mHalfBad = 0;
  endtask

  // output-side monitor: decodes the serial lanes at rising bit clock
  always @(negedge clk) begin
    cyc++;
    if (monOn) begin
      if (bclk && !mPrevB) begin
        if (mLastRise >= 0 && (cyc - mLastRise) != 2 * mDiv) mPeriodBad++;
        mLastRise = cyc;
        if (!lrck && mPrevL) monFrameDone();
        if (lrck != mPrevL) begin
          if (mSlot != 31) mHalfBad++;
          mSlot = 0;
        end else mSlot++;
        mPrevL = lrck;
        for (int l = 0; l < 4; l++) begin
          if (mSlot == 0) acc[l][lrck] = '0;
          if (mSlot >= mStart && mSlot < mStart + W)
            acc[l][lrck] = {acc[l][lrck][30:0], sdOut[l]};
          else if (sdOut[l]) mNoise++;
        end
      end
      mPrevB = bclk;
    end
  end

  // input-side serializer: drives sdIn after each falling bit clock
  always @(negedge clk) begin
    if (rxOn) begin
      if (!bclk && sPrevB) begin
        if (lrck != sPrevL) begin
          sSlot = 0;
          if (!lrck) sFrame++;
        end else sSlot++;
        sPrevL = lrck;
        for (int l = 0; l < 4; l++) begin
          logic [31:0] v;
          v = rxWord(sFrame, 2 * l + int'(lrck));
          if (sFrame >= 1 && sFrame <= sFrames && l < sLanes &&
              sSlot >= sStart && sSlot < sStart + W)
            sdIn[l] = v[31 - (sSlot - sStart)];
          else sdIn[l] = 1'b0;
        end
      end
      sPrevB = bclk;
    end
  end

  // input-side consumer: throttled ready, compares captured words
  always @(negedge clk) begin
    if (rxOn) begin
      logic [31:0] e;
      rxReady = (cyc % 3) != 0;
      if (rxValid && rxReady) begin
        e = (expQ.size() > 0) ? expQ.pop_front() : 32'h0;
        chk(rxData == e, "R8", "captured word", rxData, e);
      end
    end else rxReady = 1'b0;
  end

  task automatic sendFrames(input int nFrames, input int lanes);
    for (int f = 0; f < nFrames; f++)
      for (int i = 0; i < 2 * lanes; i++) begin
        @(negedge clk);
        txValid = 1'b1;
        txData  = txWord(f, i);
        expQ.push_back(txData);
        while (!txReady) @(negedge clk);
      end
    @(negedge clk);
    txValid = 1'b0;
  endtask

  task automatic runTx(input int fmt, input int lanes, input int div,
                       input int nFrames, input string tag);
    int guard;
    cfgDirOut = 1'b1; cfgFormat = 2'(fmt); cfgLanes = 2'(lanes - 1); cfgDivHalf = 4'(div);
    mSlot = -1; mStart = startOf(fmt); mLanes = lanes; mZero = 1; mDiv = div;
    mLastRise = -1; mNoise = 0; mPeriodBad = 0; mHalfBad = 0;
    mPrevB = 1'b0; mPrevL = 1'b0; mTag = tag;
    @(negedge clk);
    monOn = 1; cfgEnable = 1'b1;
    sendFrames(nFrames, lanes);
    chk(underrun == 1'b0, "R6", "no underrun while fed", 32'(underrun), 0);
    chk(rxValid == 1'b0, "R7", "rxValid in output mode", 32'(rxValid), 0);
    guard = 0;
    while (expQ.size() > 0 && guard < 20000) begin @(negedge clk); guard++; end
    repeat (2 * 128 * div) @(negedge clk);
    chk(underrun == 1'b1, "R6", "underrun after supply stops", 32'(underrun), 1);
    chk(txReady == 1'b1, "R6", "accepting while starved", 32'(txReady), 1);
    monOn = 0; cfgEnable = 1'b0;
    repeat (2) @(negedge clk);
    chk(underrun == 1'b0 && txReady == 1'b0 && bclk == 1'b0, "R9",
        "disabled state", {underrun, txReady, bclk}, 0);
    expQ.delete();
  endtask

  task automatic runRx(input int fmt, input int lanes, input int div,
                       input int nFrames, input string tag);
    int guard;
    cfgDirOut = 1'b0; cfgFormat = 2'(fmt); cfgLanes = 2'(lanes - 1); cfgDivHalf = 4'(div);
    sSlot = 0; sFrame = 0; sStart = startOf(fmt); sLanes = lanes; sFrames = nFrames;
    sPrevB = 1'b0; sPrevL = 1'b0; sdIn = '0;
    for (int i = 0; i < 2 * lanes; i++) expQ.push_back(32'h0);
    for (int f = 1; f <= nFrames; f++)
      for (int i = 0; i < 2 * lanes; i++)
        expQ.push_back(rxWord(f, i) & ~((32'h1 << SH) - 32'h1));
    @(negedge clk);
    rxOn = 1; cfgEnable = 1'b1;
    @(negedge clk);
    chk(txReady == 1'b0, "R7", {tag, " txReady in input mode"}, 32'(txReady), 0);
    guard = 0;
    while (expQ.size() > 0 && guard < 20000) begin @(negedge clk); guard++; end
    chk(expQ.size() == 0, "R8", {tag, " all frames delivered"}, 32'(expQ.size()), 0);
    repeat (128 * div) @(negedge clk);
    rxOn = 0; cfgEnable = 1'b0; sdIn = '0;
    repeat (2) @(negedge clk);
    chk(rxValid == 1'b0, "R9", "rxValid after disable", 32'(rxValid), 0);
    expQ.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk({bclk, lrck, sdOut, txReady, rxValid, underrun} == '0, "R9",
        "reset/disabled outputs", 32'({bclk, lrck, sdOut, txReady, rxValid, underrun}), 0);
    runTx(0, 4, 1, 3, "R2");
    runTx(1, 2, 2, 3, "R3");
    runTx(2, 1, 1, 3, "R4");
    runTx(3, 3, 1, 2, "R2");
    runRx(0, 4, 1, 3, "R2");
    runRx(2, 3, 2, 3, "R4");
    runRx(1, 2, 1, 3, "R3");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule